// File: doc/BRIEF.md
# AXI4 to AXI3 Read Burst Converter

This block sits between an AXI4 read master and an AXI3 read slave. It takes incrementing read requests of up to 256 beats from the upstream port. Each request is re-issued downstream as one or more AXI3 requests of no more than 16 beats, and every piece after the first starts one 16-beat stride further along. The returning read data travels straight back upstream. The per-beat response codes are not changed. Only the last beat of the last piece is marked as last upstream, so the master sees a single burst.

A small FIFO of piece descriptors connects the address-side state machine to the read-data side. This lets the converter issue further downstream requests before earlier data has returned. The read-data path never applies backpressure of its own. Responses from one slave are only ordered within a single ID. For that reason, a new upstream request whose ID differs from the ID still in flight is held until every outstanding piece has completed.

Top module: `axi4_axi3_rd_conv`

## Requirements
- R1: An upstream request with length field L (beats minus one, 0 to 255) is issued downstream as ceil((L+1)/16) pieces. Each piece has a length field of 15, except the last, whose length field is L mod 16.
- R2: Piece k of a request with start address A is issued at address A + k*16*(DATA_W/8), computed modulo 2^ADDR_W.
- R3: Every downstream piece carries the ID of the upstream request it came from.
- R4: Read data, response code, ID and valid pass upstream unchanged in the same cycle. The downstream ready always equals the upstream ready.
- R5: The upstream last flag is high only on the final beat of the final piece of a request. It is low on the last beats of all earlier pieces.
- R6: While downstream pieces are outstanding, an upstream request with a different ID is not accepted until all of them have completed. A request with the same ID may be accepted at once.
- R7: Up to FIFO_DEPTH pieces may be outstanding before any data returns. Once FIFO_DEPTH pieces are outstanding, the downstream address valid stays low.
- R8: After an upstream request is accepted, the upstream ready is low in the next cycle and the first downstream piece is presented in that cycle, provided the FIFO has room.
- R9: A synchronous active-high reset leaves the converter idle, with the upstream ready high and the downstream address valid and upstream read valid low.
- R10: A downstream address request that is not accepted keeps its valid, address, length and ID unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_arvalid | input | 1 | Upstream read request valid |
| up_arready | output | 1 | Upstream read request ready |
| up_araddr | input | ADDR_W | Upstream start address |
| up_arlen | input | 8 | Upstream length, beats minus one |
| up_arid | input | ID_W | Upstream request ID |
| up_rvalid | output | 1 | Upstream read data valid |
| up_rready | input | 1 | Upstream read data ready |
| up_rid | output | ID_W | Upstream read ID |
| up_rdata | output | DATA_W | Upstream read data |
| up_rresp | output | 2 | Upstream per-beat response code |
| up_rlast | output | 1 | Upstream last beat of the whole request |
| dn_arvalid | output | 1 | Downstream piece request valid |
| dn_arready | input | 1 | Downstream piece request ready |
| dn_araddr | output | ADDR_W | Downstream piece address |
| dn_arlen | output | 4 | Downstream piece length, beats minus one |
| dn_arid | output | ID_W | Downstream piece ID |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rready | output | 1 | Downstream read data ready |
| dn_rid | input | ID_W | Downstream read ID |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_rresp | input | 2 | Downstream per-beat response code |
| dn_rlast | input | 1 | Downstream last beat of a piece |

## Verification
The assertions assume a well-behaved downstream slave. It returns exactly one last-flagged beat for each accepted piece, in the order the pieces were issued, and sends no data when no piece is outstanding. They also assume upstream requests are incrementing bursts sized to the full data width. The bench slave records every accepted piece and answers pieces strictly in that order, returning exactly the recorded number of beats. A pause switch holds its data back, which lets the ID stall and the full FIFO be observed without ever breaking those assumptions.

// File: rtl/axi4_axi3_rd_conv_pkg.sv
package axi4_axi3_rd_conv_pkg;

    localparam int unsigned UP_LEN_W     = 8;
    localparam int unsigned DN_LEN_W     = 4;
    localparam int unsigned DN_MAX_BEATS = 16;
    localparam int unsigned RESP_W       = 2;

    typedef enum logic [0:0] {
        SPL_IDLE  = 1'b0,
        SPL_ISSUE = 1'b1
    } spl_state_e;

    // One descriptor per downstream piece, consumed by the read-data side.
    typedef struct packed {
        logic final_piece;
    } piece_desc_t;

    // Length field of the next piece, given the remaining beats minus one.
    function automatic logic [DN_LEN_W-1:0] next_piece_len(input logic [UP_LEN_W-1:0] rem);
        if (rem >= UP_LEN_W'(DN_MAX_BEATS))
            return DN_LEN_W'(DN_MAX_BEATS - 1);
        else
            return rem[DN_LEN_W-1:0];
    endfunction

    function automatic logic is_last_piece(input logic [UP_LEN_W-1:0] rem);
        return rem < UP_LEN_W'(DN_MAX_BEATS);
    endfunction

endpackage

// File: rtl/axi4_axi3_rd_desc_fifo.sv
module axi4_axi3_rd_desc_fifo #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= ptr_next(wr_ptr);
            if (pop)
                rd_ptr <= ptr_next(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign full    = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/axi4_axi3_rd_splitter.sv
module axi4_axi3_rd_splitter
    import axi4_axi3_rd_conv_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 3,
    localparam int unsigned STRIDE = DN_MAX_BEATS * (DATA_W / 8)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                up_arvalid,
    output logic                up_arready,
    input  logic [ADDR_W-1:0]   up_araddr,
    input  logic [UP_LEN_W-1:0] up_arlen,
    input  logic [ID_W-1:0]     up_arid,
    output logic                dn_arvalid,
    input  logic                dn_arready,
    output logic [ADDR_W-1:0]   dn_araddr,
    output logic [DN_LEN_W-1:0] dn_arlen,
    output logic [ID_W-1:0]     dn_arid,
    input  logic                fifo_full,
    input  logic [CNT_W-1:0]    outstanding,
    output logic                push,
    output piece_desc_t         push_desc
);

    spl_state_e          state;
    logic [ADDR_W-1:0]   cur_addr;
    logic [UP_LEN_W-1:0] rem;
    logic [ID_W-1:0]     cur_id;
    logic                id_ok;
    logic                accept;

    // Different ID may only enter once nothing is in flight.
    assign id_ok      = (outstanding == '0) || (up_arid == cur_id);
    assign up_arready = (state == SPL_IDLE) && id_ok;
    assign accept     = up_arvalid && up_arready;

    assign dn_arvalid = (state == SPL_ISSUE) && !fifo_full;
    assign dn_araddr  = cur_addr;
    assign dn_arlen   = next_piece_len(rem);
    assign dn_arid    = cur_id;

    assign push                  = dn_arvalid && dn_arready;
    assign push_desc.final_piece = is_last_piece(rem);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SPL_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            cur_id   <= '0;
        end else begin
            case (state)
                SPL_IDLE: begin
                    if (accept) begin
                        cur_addr <= up_araddr;
                        rem      <= up_arlen;
                        cur_id   <= up_arid;
                        state    <= SPL_ISSUE;
                    end
                end
                SPL_ISSUE: begin
                    if (push) begin
                        if (is_last_piece(rem)) begin
                            state <= SPL_IDLE;
                        end else begin
                            rem      <= rem - UP_LEN_W'(DN_MAX_BEATS);
                            cur_addr <= cur_addr + ADDR_W'(STRIDE);
                        end
                    end
                end
                default: state <= SPL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/axi4_axi3_rd_merger.sv
module axi4_axi3_rd_merger
    import axi4_axi3_rd_conv_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              dn_rvalid,
    output logic              dn_rready,
    input  logic [ID_W-1:0]   dn_rid,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [RESP_W-1:0] dn_rresp,
    input  logic              dn_rlast,
    output logic              up_rvalid,
    input  logic              up_rready,
    output logic [ID_W-1:0]   up_rid,
    output logic [DATA_W-1:0] up_rdata,
    output logic [RESP_W-1:0] up_rresp,
    output logic              up_rlast,
    input  piece_desc_t       head_desc,
    output logic              pop
);

    assign up_rvalid = dn_rvalid;
    assign dn_rready = up_rready;
    assign up_rid    = dn_rid;
    assign up_rdata  = dn_rdata;
    assign up_rresp  = dn_rresp;

    // Only the closing piece of a request may end the upstream burst.
    assign up_rlast  = dn_rlast && head_desc.final_piece;
    assign pop       = dn_rvalid && up_rready && dn_rlast;

endmodule

// File: rtl/axi4_axi3_rd_conv.sv
module axi4_axi3_rd_conv
    import axi4_axi3_rd_conv_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_arvalid,
    output logic              up_arready,
    input  logic [ADDR_W-1:0] up_araddr,
    input  logic [7:0]        up_arlen,
    input  logic [ID_W-1:0]   up_arid,
    output logic              up_rvalid,
    input  logic              up_rready,
    output logic [ID_W-1:0]   up_rid,
    output logic [DATA_W-1:0] up_rdata,
    output logic [1:0]        up_rresp,
    output logic              up_rlast,
    output logic              dn_arvalid,
    input  logic              dn_arready,
    output logic [ADDR_W-1:0] dn_araddr,
    output logic [3:0]        dn_arlen,
    output logic [ID_W-1:0]   dn_arid,
    input  logic              dn_rvalid,
    output logic              dn_rready,
    input  logic [ID_W-1:0]   dn_rid,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_rresp,
    input  logic              dn_rlast
);

    localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned DESC_W = $bits(piece_desc_t);

    logic               push;
    logic               pop;
    logic               fifo_full;
    logic [CNT_W-1:0]   fifo_count;
    piece_desc_t        push_desc;
    piece_desc_t        head_desc;
    logic [DESC_W-1:0]  head_bits;

    axi4_axi3_rd_splitter #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_splitter (
        .clk         (clk),
        .rst         (rst),
        .up_arvalid  (up_arvalid),
        .up_arready  (up_arready),
        .up_araddr   (up_araddr),
        .up_arlen    (up_arlen),
        .up_arid     (up_arid),
        .dn_arvalid  (dn_arvalid),
        .dn_arready  (dn_arready),
        .dn_araddr   (dn_araddr),
        .dn_arlen    (dn_arlen),
        .dn_arid     (dn_arid),
        .fifo_full   (fifo_full),
        .outstanding (fifo_count),
        .push        (push),
        .push_desc   (push_desc)
    );

    axi4_axi3_rd_desc_fifo #(
        .WIDTH (DESC_W),
        .DEPTH (FIFO_DEPTH)
    ) u_desc_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_data (push_desc),
        .pop     (pop),
        .rd_data (head_bits),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    assign head_desc = piece_desc_t'(head_bits);

    axi4_axi3_rd_merger #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W)
    ) u_merger (
        .dn_rvalid (dn_rvalid),
        .dn_rready (dn_rready),
        .dn_rid    (dn_rid),
        .dn_rdata  (dn_rdata),
        .dn_rresp  (dn_rresp),
        .dn_rlast  (dn_rlast),
        .up_rvalid (up_rvalid),
        .up_rready (up_rready),
        .up_rid    (up_rid),
        .up_rdata  (up_rdata),
        .up_rresp  (up_rresp),
        .up_rlast  (up_rlast),
        .head_desc (head_desc),
        .pop       (pop)
    );

endmodule

// File: rtl/axi4_axi3_rd_conv_chk.sv
module axi4_axi3_rd_conv_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              up_arvalid,
    input logic              up_arready,
    input logic [ID_W-1:0]   up_arid,
    input logic              dn_arvalid,
    input logic              dn_arready,
    input logic [ADDR_W-1:0] dn_araddr,
    input logic [3:0]        dn_arlen,
    input logic [ID_W-1:0]   dn_arid,
    input logic              dn_rvalid,
    input logic              dn_rready,
    input logic              dn_rlast,
    input logic              up_rvalid,
    input logic              up_rlast
);

    logic [CW-1:0]   chk_cnt;
    logic [ID_W-1:0] chk_id;
    logic            ar_hs;
    logic            piece_done;

    assign ar_hs      = dn_arvalid && dn_arready;
    assign piece_done = dn_rvalid && dn_rready && dn_rlast;

    always_ff @(posedge clk) begin
        if (rst)
            chk_cnt <= '0;
        else
            chk_cnt <= chk_cnt + CW'(ar_hs) - CW'(piece_done);
    end

    always_ff @(posedge clk) begin
        if (ar_hs)
            chk_id <= dn_arid;
    end

    assert_id_throttle_R6: assert property (@(posedge clk) disable iff (rst)
        (up_arvalid && up_arready && chk_cnt != '0) |-> (up_arid == chk_id));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        chk_cnt <= CW'(FIFO_DEPTH));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (up_arvalid && up_arready) |=> !up_arready);

    assert_request_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (dn_arvalid && !dn_arready) |=>
            (dn_arvalid && $stable(dn_araddr) && $stable(dn_arlen) && $stable(dn_arid)));

    assert_last_gated_R5: assert property (@(posedge clk) disable iff (rst)
        up_rlast |-> (up_rvalid && dn_rlast));

endmodule

bind axi4_axi3_rd_conv axi4_axi3_rd_conv_chk #(
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .up_arvalid (up_arvalid),
    .up_arready (up_arready),
    .up_arid    (up_arid),
    .dn_arvalid (dn_arvalid),
    .dn_arready (dn_arready),
    .dn_araddr  (dn_araddr),
    .dn_arlen   (dn_arlen),
    .dn_arid    (dn_arid),
    .dn_rvalid  (dn_rvalid),
    .dn_rready  (dn_rready),
    .dn_rlast   (dn_rlast),
    .up_rvalid  (up_rvalid),
    .up_rlast   (up_rlast)
);

// File: tb/axi4_axi3_rd_conv_tb.sv
module axi4_axi3_rd_conv_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int ID_W       = 4;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = 4;
    localparam int STEP       = 16 * DATA_W / 8;
    localparam int NVEC       = 6;

    // {id[51:48], addr[47:16], len[15:8], expected pieces[7:0]}
    localparam logic [51:0] VEC [NVEC] = '{
        {4'd1, 32'h0000_0000, 8'd255, 8'd16},
        {4'd2, 32'h0001_0040, 8'd16,  8'd2},
        {4'd3, 32'h0002_0000, 8'd0,   8'd1},
        {4'd4, 32'h0003_0000, 8'd15,  8'd1},
        {4'd1, 32'hFFFF_FFC0, 8'd31,  8'd2},
        {4'd6, 32'h0005_0000, 8'd100, 8'd7}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              up_arvalid = 1'b0;
    logic              up_arready;
    logic [ADDR_W-1:0] up_araddr  = '0;
    logic [7:0]        up_arlen   = '0;
    logic [ID_W-1:0]   up_arid    = '0;
    logic              up_rvalid;
    logic              up_rready  = 1'b1;
    logic [ID_W-1:0]   up_rid;
    logic [DATA_W-1:0] up_rdata;
    logic [1:0]        up_rresp;
    logic              up_rlast;
    logic              dn_arvalid;
    logic              dn_arready = 1'b0;
    logic [ADDR_W-1:0] dn_araddr;
    logic [3:0]        dn_arlen;
    logic [ID_W-1:0]   dn_arid;
    logic              dn_rvalid  = 1'b0;
    logic              dn_rready;
    logic [ID_W-1:0]   dn_rid     = '0;
    logic [DATA_W-1:0] dn_rdata   = '0;
    logic [1:0]        dn_rresp   = '0;
    logic              dn_rlast   = 1'b0;

    axi4_axi3_rd_conv #(
        .ADDR_W     (ADDR_W),
        .ID_W       (ID_W),
        .DATA_W     (DATA_W),
        .FIFO_DEPTH (DEPTH)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .up_arvalid (up_arvalid),
        .up_arready (up_arready),
        .up_araddr  (up_araddr),
        .up_arlen   (up_arlen),
        .up_arid    (up_arid),
        .up_rvalid  (up_rvalid),
        .up_rready  (up_rready),
        .up_rid     (up_rid),
        .up_rdata   (up_rdata),
        .up_rresp   (up_rresp),
        .up_rlast   (up_rlast),
        .dn_arvalid (dn_arvalid),
        .dn_arready (dn_arready),
        .dn_araddr  (dn_araddr),
        .dn_arlen   (dn_arlen),
        .dn_arid    (dn_arid),
        .dn_rvalid  (dn_rvalid),
        .dn_rready  (dn_rready),
        .dn_rid     (dn_rid),
        .dn_rdata   (dn_rdata),
        .dn_rresp   (dn_rresp),
        .dn_rlast   (dn_rlast)
    );

    int checks = 0;
    int fails  = 0;

    // Upstream requests accepted, in order.
    logic [ADDR_W-1:0] ub_addr [64];
    int                ub_len  [64];
    logic [ID_W-1:0]   ub_id   [64];
    int                ub_pcs  [64];
    int ub_wr   = 0;
    int ub_ar   = 0;
    int piece_k = 0;
    int ub_rd   = 0;
    int ub_beat = 0;

    // Downstream pieces accepted, in order.
    int              pc_len [512];
    logic [ID_W-1:0] pc_id  [512];
    int pc_wr = 0;
    int pc_rd = 0;

    logic pause    = 1'b0;
    int   tx_seed  = 0;
    int   rx_seed  = 0;
    int   cyc      = 0;

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Downstream address ready: low every third cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            dn_arready = (cyc % 3) != 0;
        end
    end

    // Downstream address monitor: per-piece length, address and ID.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && dn_arvalid && dn_arready) begin
                int rem;
                int exp_len;
                logic [ADDR_W-1:0] exp_addr;
                rem      = ub_len[ub_ar] - 16 * piece_k;
                exp_len  = (rem >= 16) ? 15 : rem;
                exp_addr = ub_addr[ub_ar] + ADDR_W'(piece_k * STEP);
                check(int'(dn_arlen) == exp_len, "R1", "piece length", dn_arlen, exp_len);
                check(dn_araddr == exp_addr, "R2", "piece address", dn_araddr, exp_addr);
                check(dn_arid == ub_id[ub_ar], "R3", "piece id", dn_arid, ub_id[ub_ar]);
                pc_len[pc_wr] = int'(dn_arlen);
                pc_id[pc_wr]  = dn_arid;
                pc_wr++;
                ub_pcs[ub_ar]++;
                if (rem < 16) begin
                    ub_ar++;
                    piece_k = 0;
                end else begin
                    piece_k++;
                end
            end
        end
    end

    // Downstream slave: answers pieces strictly in issue order.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!pause && pc_rd < pc_wr) begin
                for (int b = 0; b <= pc_len[pc_rd]; b++) begin
                    dn_rvalid = 1'b1;
                    dn_rdata  = 32'hA500_0000 ^ DATA_W'(tx_seed);
                    dn_rresp  = 2'(tx_seed);
                    dn_rid    = pc_id[pc_rd];
                    dn_rlast  = (b == pc_len[pc_rd]);
                    tx_seed++;
                    @(posedge clk);
                    while (!up_rready) @(posedge clk);
                    #1;
                end
                dn_rvalid = 1'b0;
                dn_rlast  = 1'b0;
                pc_rd++;
            end
        end
    end

    // Upstream read monitor: data, response and last placement.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && up_rvalid && up_rready) begin
                logic exp_last;
                logic [DATA_W-1:0] exp_data;
                exp_data = 32'hA500_0000 ^ DATA_W'(rx_seed);
                check(up_rdata == exp_data && up_rresp == 2'(rx_seed) && up_rid == ub_id[ub_rd],
                      "R4", "beat data/resp", up_rdata, exp_data);
                rx_seed++;
                exp_last = (ub_beat == ub_len[ub_rd]);
                check(up_rlast == exp_last, "R5", "upstream last", up_rlast, exp_last);
                if (exp_last) begin
                    ub_rd++;
                    ub_beat = 0;
                end else begin
                    ub_beat++;
                end
            end
        end
    end

    task automatic record_req(input logic [ADDR_W-1:0] a, input int l, input logic [ID_W-1:0] i);
        ub_addr[ub_wr] = a;
        ub_len[ub_wr]  = l;
        ub_id[ub_wr]   = i;
        ub_pcs[ub_wr]  = 0;
        ub_wr++;
    endtask

    task automatic send_req(input logic [ADDR_W-1:0] a, input int l, input logic [ID_W-1:0] i);
        @(posedge clk);
        #1;
        up_arvalid = 1'b1;
        up_araddr  = a;
        up_arlen   = 8'(l);
        up_arid    = i;
        @(negedge clk);
        while (!up_arready) @(negedge clk);
        record_req(a, l, i);
        @(posedge clk);
        #1;
        up_arvalid = 1'b0;
    endtask

    task automatic wait_drain;
        @(negedge clk);
        while (ub_rd < ub_wr || pc_rd < pc_wr) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual %0d cycles expected completion", 150000);
        summary();
        $finish;
    end

    initial begin
        int base_idx;
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;

        // R9: idle after reset
        @(negedge clk);
        check(up_arready == 1'b1, "R9", "arready after reset", up_arready, 1);
        check(dn_arvalid == 1'b0, "R9", "dn_arvalid after reset", dn_arvalid, 0);
        check(up_rvalid == 1'b0, "R9", "up_rvalid after reset", up_rvalid, 0);

        // R4: ready passes straight through
        up_rready = 1'b0;
        @(negedge clk);
        check(dn_rready == 1'b0, "R4", "dn_rready low", dn_rready, 0);
        up_rready = 1'b1;
        @(negedge clk);
        check(dn_rready == 1'b1, "R4", "dn_rready high", dn_rready, 1);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            base_idx = ub_wr;
            send_req(VEC[v][47:16], int'(VEC[v][15:8]), VEC[v][51:48]);
            @(negedge clk);
            check(dn_arvalid == 1'b1, "R8", "first piece next cycle", dn_arvalid, 1);
            check(up_arready == 1'b0, "R8", "busy while issuing", up_arready, 0);
            wait_drain();
            check(ub_pcs[base_idx] == int'(VEC[v][7:0]), "R1", "piece count",
                  ub_pcs[base_idx], VEC[v][7:0]);
        end

        // R6: a different ID waits for all outstanding data
        pause = 1'b1;
        send_req(32'h0000_1000, 40, 4'd1);
        repeat (10) @(negedge clk);
        @(posedge clk);
        #1;
        up_arvalid = 1'b1;
        up_araddr  = 32'h0000_8000;
        up_arlen   = 8'd0;
        up_arid    = 4'd2;
        begin
            int seen_ready;
            seen_ready = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (up_arready) seen_ready++;
            end
            check(seen_ready == 0, "R6", "different id held", seen_ready, 0);
        end
        pause = 1'b0;
        @(negedge clk);
        while (!up_arready) @(negedge clk);
        check(ub_rd == ub_wr, "R6", "older data drained before accept", ub_rd, ub_wr);
        record_req(32'h0000_8000, 0, 4'd2);
        @(posedge clk);
        #1;
        up_arvalid = 1'b0;
        wait_drain();

        // R6 / R7: same ID runs ahead of returning data
        pause = 1'b1;
        send_req(32'h0000_2000, 0, 4'd3);
        send_req(32'h0000_3000, 0, 4'd3);
        repeat (6) @(negedge clk);
        check(pc_wr - pc_rd == 2, "R6", "same id issued while data pending", pc_wr - pc_rd, 2);
        pause = 1'b0;
        wait_drain();

        // R7: FIFO full blocks further pieces
        pause = 1'b1;
        base_idx = ub_wr;
        send_req(32'h0004_0000, 255, 4'd5);
        repeat (20) @(negedge clk);
        check(pc_wr - pc_rd == DEPTH, "R7", "pieces outstanding at full", pc_wr - pc_rd, DEPTH);
        check(dn_arvalid == 1'b0, "R7", "dn_arvalid low when full", dn_arvalid, 0);
        pause = 1'b0;
        wait_drain();
        check(ub_pcs[base_idx] == 16, "R1", "pieces after full stall", ub_pcs[base_idx], 16);

        summary();
        $finish;
    end

endmodule